// File: doc/BRIEF.md
# Doorbell Mailbox Between Host and Service Controller

This block is a small memory-mapped mailbox that links a host processor to a service controller. The host loads up to sixteen bytes of request data, sets a source pointer and a destination pointer, and then writes a command word. That command write is the doorbell. It latches the command, sets a busy flag and sends a one-cycle interrupt to the controller.

The controller reads the latched command, the pointers and the write buffer on its own side port, and it fills a sixteen-byte response buffer with byte enables. It ends the exchange with a done strobe that carries an error flag, an eight-bit error code and an initiator id. Busy then clears. If the command word asked for an interrupt on completion, the host receives a one-cycle pulse that needs no clearing. The host polls a packed status word to see busy and the error result.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the status word reads 0, `ctl_busy` is 0, and neither interrupt output is high.
- R2: A host write to offset 0x00 while busy is 0 latches the command word onto `ctl_cmd`, sets busy and drives `doorbell_irq` high for exactly the next cycle. The command word fields are size [23:16], command id [15:12], ioc [8] and opcode [7:0].
- R3: Busy stays 1 from the accepted command write until the controller gives a done strobe. The status word at offset 0x04 is {8'h0, error code[23:16], initiator id[15:8], command id[7:4], 2'b0, error[1], busy[0]}. The command id is taken from the latched command.
- R4: A done strobe while busy clears busy and captures the error flag, the error code and the initiator id into status. These fields keep their values until the next accepted done.
- R5: An accepted done when the latched command has ioc=1 drives `host_irq` high for exactly one cycle. When ioc=0, `host_irq` stays low.
- R6: A command write while busy is ignored: `ctl_cmd` does not change and no doorbell is raised.
- R7: Host writes to the source pointer (0x08), the destination pointer (0x0C) and the write buffer words (0x80 to 0x8C, with the byte at offset 0x80+n on `ctl_wbuf[8n+7:8n]`) appear on the controller port. Host reads of these locations and of offset 0x00 return 0.
- R8: `ctl_wvalid[n]` is 1 exactly when n is less than the latched size field. A size of 16 or more marks all sixteen bytes valid.
- R9: Controller byte writes (`ctl_rb_we[n]` loads `ctl_rb_data[8n+7:8n]` into byte n) are readable by the host as words at 0x90 to 0x9C, little-endian. Host writes to the read buffer or to the status word have no effect.
- R10: A done strobe while busy is 0 is ignored: the status does not change and no `host_irq` is raised.
- R11: The read data is valid on `h_rdata`, with `h_rvalid` high, in the cycle after the cycle in which `h_rd` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | AW | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_rvalid | output | 1 | Read data valid |
| doorbell_irq | output | 1 | One-cycle interrupt to the controller |
| host_irq | output | 1 | One-cycle completion interrupt to the host |
| ctl_cmd | output | 32 | Latched command word |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_wbuf | output | 8*BUF_BYTES | Write buffer contents |
| ctl_wvalid | output | BUF_BYTES | Valid-byte mask derived from size |
| ctl_busy | output | 1 | Busy flag |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag given with done |
| ctl_err_code | input | 8 | Error code given with done |
| ctl_init_id | input | 8 | Initiator id given with done |
| ctl_rb_we | input | BUF_BYTES | Read buffer byte enables |
| ctl_rb_data | input | 8*BUF_BYTES | Read buffer byte data |

## Verification
Each state change takes one register stage. A command write, a done strobe or a controller byte write shows on the ports one cycle after the edge that samples it, and a host read returns its word one cycle after `h_rd`. The bench drives inputs on falling edges and samples one falling edge later, so each result is read in the cycle it first becomes valid. It samples again one cycle after that to confirm that each interrupt pulse has dropped. Read results go to an expectation queue, and the monitor pops an entry whenever `h_rvalid` is seen, so every word is compared in its own due cycle.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int AW = 8,
  parameter int BUF_BYTES = 16,
  localparam int NW = BUF_BYTES / 4,
  localparam int IW = $clog2(NW),
  localparam int BW = BUF_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [AW-1:0]     h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_rvalid,
  output logic              doorbell_irq,
  output logic              host_irq,
  output logic [31:0]       ctl_cmd,
  output logic [31:0]       ctl_sptr,
  output logic [31:0]       ctl_dptr,
  output logic [BW-1:0]     ctl_wbuf,
  output logic [BUF_BYTES-1:0] ctl_wvalid,
  output logic              ctl_busy,
  input  logic              ctl_done,
  input  logic              ctl_err,
  input  logic [7:0]        ctl_err_code,
  input  logic [7:0]        ctl_init_id,
  input  logic [BUF_BYTES-1:0] ctl_rb_we,
  input  logic [BW-1:0]     ctl_rb_data
);

  localparam logic [AW-1:0] A_CMD  = AW'('h00);
  localparam logic [AW-1:0] A_STAT = AW'('h04);
  localparam logic [AW-1:0] A_SPTR = AW'('h08);
  localparam logic [AW-1:0] A_DPTR = AW'('h0C);
  localparam logic [AW-1:0] A_WB   = AW'('h80);
  localparam logic [AW-1:0] A_RB   = AW'('h80 + BUF_BYTES);
  localparam logic [AW-1:0] A_END  = AW'('h80 + 2 * BUF_BYTES);

  logic [31:0] cmd_q, sptr_q, dptr_q;
  logic [31:0] wbuf_q [NW];
  logic [7:0]  rbuf_q [BUF_BYTES];
  logic        busy_q, err_q, dbl_q, hirq_q;
  logic [7:0]  ecode_q, init_q;
  logic [31:0] status, rd_val;

  logic [AW-1:0] wb_off, rb_off;
  logic [IW-1:0] wb_idx, rb_idx;
  logic          in_wb, in_rb, cmd_acc, done_acc;

  assign wb_off   = h_addr - A_WB;
  assign rb_off   = h_addr - A_RB;
  assign wb_idx   = wb_off[IW+1:2];
  assign rb_idx   = rb_off[IW+1:2];
  assign in_wb    = (h_addr >= A_WB) && (h_addr < A_RB);
  assign in_rb    = (h_addr >= A_RB) && (h_addr < A_END);
  assign cmd_acc  = h_wr && (h_addr == A_CMD) && !busy_q;
  assign done_acc = ctl_done && busy_q;

  assign status = {8'h00, ecode_q, init_q, cmd_q[15:12], 2'b00, err_q, busy_q};

  always_comb begin
    rd_val = '0;
    if (h_addr == A_STAT) rd_val = status;
    else if (in_rb)
      rd_val = {rbuf_q[{rb_idx, 2'd3}], rbuf_q[{rb_idx, 2'd2}],
                rbuf_q[{rb_idx, 2'd1}], rbuf_q[{rb_idx, 2'd0}]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      sptr_q  <= '0;
      dptr_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ecode_q <= '0;
      init_q  <= '0;
      dbl_q   <= 1'b0;
      hirq_q  <= 1'b0;
      h_rdata <= '0;
      h_rvalid <= 1'b0;
      for (int i = 0; i < NW; i++) wbuf_q[i] <= '0;
      for (int i = 0; i < BUF_BYTES; i++) rbuf_q[i] <= '0;
    end else begin
      dbl_q    <= cmd_acc;
      hirq_q   <= done_acc && cmd_q[8];
      h_rvalid <= h_rd;
      if (h_rd) h_rdata <= rd_val;
      if (cmd_acc) begin
        cmd_q  <= h_wdata;
        busy_q <= 1'b1;
      end else if (done_acc) begin
        busy_q  <= 1'b0;
        err_q   <= ctl_err;
        ecode_q <= ctl_err_code;
        init_q  <= ctl_init_id;
      end
      if (h_wr && h_addr == A_SPTR) sptr_q <= h_wdata;
      if (h_wr && h_addr == A_DPTR) dptr_q <= h_wdata;
      if (h_wr && in_wb) wbuf_q[wb_idx] <= h_wdata;
      for (int i = 0; i < BUF_BYTES; i++)
        if (ctl_rb_we[i]) rbuf_q[i] <= ctl_rb_data[8*i +: 8];
    end
  end

  assign doorbell_irq = dbl_q;
  assign host_irq     = hirq_q;
  assign ctl_cmd      = cmd_q;
  assign ctl_sptr     = sptr_q;
  assign ctl_dptr     = dptr_q;
  assign ctl_busy     = busy_q;

  for (genvar w = 0; w < NW; w++) begin : g_wb
    assign ctl_wbuf[32*w +: 32] = wbuf_q[w];
  end

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_wv
    assign ctl_wvalid[b] = (cmd_q[23:16] > 8'(b));
  end

endmodule

module ipc_mailbox_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic          h_rd,
  input logic [AW-1:0] h_addr,
  input logic          h_rvalid,
  input logic          doorbell_irq,
  input logic          host_irq,
  input logic [31:0]   ctl_cmd,
  input logic          ctl_busy,
  input logic          ctl_done
);

  assert_doorbell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == '0 && !ctl_busy) |=> (doorbell_irq && ctl_busy));

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && !ctl_done) |=> ctl_busy);

  assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && ctl_done && !(h_wr && h_addr == '0)) |=> !ctl_busy);

  assert_hirq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  assert_hirq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && ctl_done && ctl_cmd[8]) |=> host_irq);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && h_wr && h_addr == '0) |=> ($stable(ctl_cmd) && !doorbell_irq));

  assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_busy && ctl_done) |=> !host_irq);

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> h_rvalid);

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.AW(AW)) u_chk (.*);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NB = 16;

  logic clk = 0, rst_n = 0;
  logic h_wr = 0, h_rd = 0;
  logic [AW-1:0] h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic h_rvalid, doorbell_irq, host_irq, ctl_busy;
  logic [31:0] ctl_cmd, ctl_sptr, ctl_dptr;
  logic [8*NB-1:0] ctl_wbuf;
  logic [NB-1:0] ctl_wvalid;
  logic ctl_done = 0, ctl_err = 0;
  logic [7:0] ctl_err_code = '0, ctl_init_id = '0;
  logic [NB-1:0] ctl_rb_we = '0;
  logic [8*NB-1:0] ctl_rb_data = '0;

  int checks = 0, fails = 0;
  logic [31:0] q_exp[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox #(.AW(AW), .BUF_BYTES(NB)) u_ipc_mailbox (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && h_rvalid) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 actual=unexpected read expected=none");
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, h_rdata, e);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    h_rd = 1; h_addr = a;
    q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    h_rd = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 0;
  endtask

  task automatic cmd(input logic [31:0] d, input logic exp_db, input string tag);
    wr(8'h00, d);
    chk(tag, doorbell_irq, exp_db);
    @(negedge clk);
    chk(tag, doorbell_irq, 1'b0);
  endtask

  task automatic done(input logic e, input logic [7:0] code, input logic [7:0] iid,
                      input logic exp_irq, input string tag);
    @(negedge clk);
    ctl_done = 1; ctl_err = e; ctl_err_code = code; ctl_init_id = iid;
    @(negedge clk);
    ctl_done = 0;
    chk(tag, host_irq, exp_irq);
    @(negedge clk);
    chk(tag, host_irq, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", ctl_busy, 1'b0);
    chk("R1 irq", {doorbell_irq, host_irq}, 2'b00);
    rd(8'h04, 32'h0, "R1 status");

    wr(8'h08, 32'h1111_2222);
    wr(8'h0C, 32'h3333_4444);
    for (int i = 0; i < 4; i++) wr(8'(8'h80 + 4*i), 32'hA0B0_C000 + 32'(i));
    chk("R7 sptr", ctl_sptr, 32'h1111_2222);
    chk("R7 dptr", ctl_dptr, 32'h3333_4444);
    chk("R7 wbuf", ctl_wbuf, {32'hA0B0_C003, 32'hA0B0_C002, 32'hA0B0_C001, 32'hA0B0_C000});
    rd(8'h08, 32'h0, "R7 sptr read");
    rd(8'h0C, 32'h0, "R7 dptr read");
    rd(8'h84, 32'h0, "R7 wbuf read");

    cmd(32'h0005_A1FF, 1'b1, "R2 doorbell");
    chk("R2 ctl_cmd", ctl_cmd, 32'h0005_A1FF);
    chk("R8 size5", ctl_wvalid, 16'h001F);
    rd(8'h00, 32'h0, "R7 cmd read");
    rd(8'h04, 32'h0000_00A1, "R3 status busy");
    repeat (5) @(negedge clk);
    chk("R3 busy hold", ctl_busy, 1'b1);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_00A1, "R9 status write ignored");
    done(1'b1, 8'h3C, 8'h55, 1'b1, "R5 ioc irq");
    chk("R4 busy clear", ctl_busy, 1'b0);
    rd(8'h04, 32'h003C_55A2, "R4 status done");

    cmd(32'h0010_3005, 1'b1, "R2 doorbell2");
    chk("R8 size16", ctl_wvalid, 16'hFFFF);
    rd(8'h04, 32'h003C_5533, "R4 fields held");
    cmd(32'h0000_7000, 1'b0, "R6 busy write");
    chk("R6 cmd kept", ctl_cmd, 32'h0010_3005);
    chk("R6 size kept", ctl_wvalid, 16'hFFFF);
    done(1'b0, 8'h00, 8'h12, 1'b0, "R5 no ioc");
    rd(8'h04, 32'h0000_1230, "R4 status done2");

    done(1'b1, 8'hFF, 8'h77, 1'b0, "R10 idle done irq");
    rd(8'h04, 32'h0000_1230, "R10 status unchanged");

    cmd(32'h0014_0000, 1'b1, "R2 doorbell3");
    chk("R8 size20", ctl_wvalid, 16'hFFFF);
    done(1'b0, 8'h00, 8'h00, 1'b0, "R5 no ioc2");
    cmd(32'h0000_0000, 1'b1, "R2 doorbell4");
    chk("R8 size0", ctl_wvalid, 16'h0000);
    done(1'b0, 8'h00, 8'h00, 1'b0, "R5 no ioc3");

    @(negedge clk);
    ctl_rb_we = '1;
    for (int i = 0; i < NB; i++) ctl_rb_data[8*i +: 8] = 8'(i);
    @(negedge clk);
    ctl_rb_we = 16'h0030;
    ctl_rb_data = {NB{8'hEE}};
    @(negedge clk);
    ctl_rb_we = '0;
    rd(8'h90, 32'h0302_0100, "R9 rbuf0");
    rd(8'h94, 32'h0706_EEEE, "R9 rbuf1 partial");
    rd(8'h9C, 32'h0F0E_0D0C, "R9 rbuf3");
    wr(8'h94, 32'hDEAD_BEEF);
    rd(8'h94, 32'h0706_EEEE, "R9 host write ignored");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 actual=%0d pending expected=0", q_exp.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule